// File: doc/BRIEF.md
# Configuration Image Stream Loader

The loader feeds a packed configuration image into a programmable target. Software or a DMA engine pulses a start input, and the loader then runs a fixed preamble. It asks the target to reset, waits a settle time, writes a single zero byte, and waits the settle time again. Only after that does it open its byte stream input, which uses a valid/ready handshake with a last marker.

The image starts with a sixteen-byte header. The first four bytes give the payload length, most significant byte first. The next four bytes are a version word and the four after them are a date word. The final four header bytes are reserved and are discarded. The loader passes exactly the declared number of payload bytes to the target, one write strobe per byte. It then appends five zero bytes and samples the target's error line to decide whether the load succeeded.

If the stream ends too early, either inside the header or before the declared payload has arrived, the load stops at once with both the done flag and the error flag set. The version and date words stay on dedicated outputs after the load.

Top module: `cfg_image_loader`

## Requirements
- R1: While reset is held and after it is released, in_ready_o, cfg_we_o, cfg_rst_req_o, done_o and err_o are all low.
- R2: A start pulse in idle raises cfg_rst_req_o for exactly one cycle. A single write of 0x00 follows exactly SETTLE_CYCLES+2 cycles later.
- R3: The header is the first 16 accepted bytes. Bytes 0..3 form the payload length, byte 0 being the most significant. Bytes 12..15 have no effect on any output.
- R4: After the header, version_o holds bytes 4..7 and date_o holds bytes 8..11, each with its lowest-numbered byte as the most significant.
- R5: Exactly the declared number of payload bytes is forwarded on cfg_data_o, in arrival order, with one cfg_we_o pulse per byte.
- R6: Five writes of 0x00 follow the last payload byte. in_ready_o is low while the dummy write and the padding writes are issued.
- R7: One cycle after the last padding write, done_o rises and err_o takes the value of cfg_err_i sampled in that cycle. err_o is never high without done_o.
- R8: If in_last_i arrives with fewer than 16 header bytes, or with exactly 16 header bytes and a nonzero length, done_o and err_o are set and no payload or padding write is issued.
- R9: If in_last_i arrives on a payload byte before the declared count is reached, that byte is still forwarded. The load then ends with done_o and err_o set and with no padding.
- R10: A declared length of zero moves straight from the header to the five padding writes.
- R11: Bytes offered while the loader is idle are not accepted (in_ready_o low) and produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a load when idle |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte |
| in_last_i | input | 1 | Marks the final byte of the stream |
| in_ready_o | output | 1 | Loader accepts a byte this cycle |
| cfg_rst_req_o | output | 1 | One-cycle reset request to the target |
| cfg_we_o | output | 1 | Byte write strobe to the target |
| cfg_data_o | output | 8 | Byte written to the target |
| cfg_err_i | input | 1 | Error indication from the target |
| done_o | output | 1 | Load finished, held until the next start |
| err_o | output | 1 | Load failed, held until the next start |
| version_o | output | 32 | Captured version word |
| date_o | output | 32 | Captured date word |

## Verification
Some properties are checked on every cycle by the assertions. These cover the single-cycle shape of the reset request, zero-valued write strobes in the cycle after each padding state, a nonzero remaining count throughout the payload phase, and the rule that err_o implies done_o. They also check that the settle counter never climbs except on a load, and that the header words hold still when no header byte is taken. Other properties can only be shown by the bench's scenarios, using complete images. These are the exact settle gap, the byte-for-byte order of forwarded data, the decoding of the big-endian fields, the sampling of the target error line, and the absence of writes after a short header or a truncated payload.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

    localparam int HDR_BYTES   = 16;
    localparam int FIELD_BYTES = 4;
    localparam int HDR_IDX_W   = $clog2(HDR_BYTES);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST,
        ST_WAIT_RST,
        ST_DUMMY,
        ST_WAIT_DUM,
        ST_HDR,
        ST_PAY,
        ST_PAD,
        ST_CHK
    } ldr_state_e;

endpackage

// File: rtl/cfg_ldr_settle.sv
module cfg_ldr_settle #(
    parameter int CYCLES = 4,
    parameter int CNT_W  = $clog2(CYCLES + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R2
    settle_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/cfg_ldr_hdr.sv
module cfg_ldr_hdr
    import cfg_ldr_pkg::*;
#(
    parameter int NUM_FIELDS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 wr_i,
    input  logic [HDR_IDX_W-1:0] idx_i,
    input  logic [7:0]           byte_i,
    output logic [31:0]          len_o,
    output logic [31:0]          ver_o,
    output logic [31:0]          date_o
);

    logic [31:0] field_d [NUM_FIELDS];
    logic [31:0] field_q [NUM_FIELDS];

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam logic [1:0] SLOT = 2'(f);

        always_comb begin
            field_d[f] = field_q[f];
            if (clr_i) begin
                field_d[f] = '0;
            end else if (wr_i && (idx_i[HDR_IDX_W-1:2] == SLOT)) begin
                field_d[f] = {field_q[f][23:0], byte_i};
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                field_q[f] <= '0;
            end else begin
                field_q[f] <= field_d[f];
            end
        end
    end

    assign len_o  = field_q[0];
    assign ver_o  = field_q[1];
    assign date_o = field_q[2];

    // R3
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !clr_i) |=> ($stable(len_o) && $stable(ver_o) && $stable(date_o)));

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
    import cfg_ldr_pkg::*;
#(
    parameter int LEN_W         = 32,
    parameter int SETTLE_CYCLES = 4,
    parameter int PAD_WRITES    = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        in_valid_i,
    input  logic [7:0]  in_data_i,
    input  logic        in_last_i,
    output logic        in_ready_o,
    output logic        cfg_rst_req_o,
    output logic        cfg_we_o,
    output logic [7:0]  cfg_data_o,
    input  logic        cfg_err_i,
    output logic        done_o,
    output logic        err_o,
    output logic [31:0] version_o,
    output logic [31:0] date_o
);

    localparam int PAD_W = $clog2(PAD_WRITES + 1);
    localparam logic [PAD_W-1:0]     PAD_LAST = PAD_W'(PAD_WRITES - 1);
    localparam logic [HDR_IDX_W-1:0] HDR_LAST = HDR_IDX_W'(HDR_BYTES - 1);

    typedef struct packed {
        ldr_state_e           st;
        logic [HDR_IDX_W-1:0] hidx;
        logic [LEN_W-1:0]     remain;
        logic [PAD_W-1:0]     pad;
        logic                 we;
        logic [7:0]           data;
        logic                 rst_req;
        logic                 done;
        logic                 err;
    } ldr_regs_t;

    ldr_regs_t d, q;

    logic        accept;
    logic        tmr_load;
    logic        tmr_expired;
    logic        hdr_clr;
    logic        hdr_wr;
    logic [31:0] len_word;
    logic [LEN_W-1:0] len_val;

    assign in_ready_o = (q.st == ST_HDR) || (q.st == ST_PAY);
    assign accept     = in_valid_i && in_ready_o;
    assign tmr_load   = (q.st == ST_RST) || (q.st == ST_DUMMY);
    assign hdr_clr    = (q.st == ST_IDLE) && start_i;
    assign hdr_wr     = (q.st == ST_HDR) && accept;
    assign len_val    = len_word[LEN_W-1:0];

    cfg_ldr_settle #(
        .CYCLES (SETTLE_CYCLES)
    ) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .expired_o (tmr_expired)
    );

    cfg_ldr_hdr #(
        .NUM_FIELDS (3)
    ) u_hdr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (hdr_clr),
        .wr_i   (hdr_wr),
        .idx_i  (q.hidx),
        .byte_i (in_data_i),
        .len_o  (len_word),
        .ver_o  (version_o),
        .date_o (date_o)
    );

    always_comb begin
        d         = q;
        d.we      = 1'b0;
        d.rst_req = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st   = ST_RST;
                    d.done = 1'b0;
                    d.err  = 1'b0;
                end
            end
            ST_RST: begin
                d.rst_req = 1'b1;
                d.st      = ST_WAIT_RST;
            end
            ST_WAIT_RST: begin
                if (tmr_expired) begin
                    d.st = ST_DUMMY;
                end
            end
            ST_DUMMY: begin
                d.we   = 1'b1;
                d.data = 8'h00;
                d.st   = ST_WAIT_DUM;
            end
            ST_WAIT_DUM: begin
                if (tmr_expired) begin
                    d.st   = ST_HDR;
                    d.hidx = '0;
                end
            end
            ST_HDR: begin
                if (accept) begin
                    d.hidx = q.hidx + HDR_IDX_W'(1);
                    if (q.hidx == HDR_LAST) begin
                        if (len_val == '0) begin
                            d.st  = ST_PAD;
                            d.pad = '0;
                        end else if (in_last_i) begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                            d.err  = 1'b1;
                        end else begin
                            d.st     = ST_PAY;
                            d.remain = len_val;
                        end
                    end else if (in_last_i) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end
                end
            end
            ST_PAY: begin
                if (accept) begin
                    d.we     = 1'b1;
                    d.data   = in_data_i;
                    d.remain = q.remain - LEN_W'(1);
                    if (q.remain == LEN_W'(1)) begin
                        d.st  = ST_PAD;
                        d.pad = '0;
                    end else if (in_last_i) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end
                end
            end
            ST_PAD: begin
                d.we   = 1'b1;
                d.data = 8'h00;
                d.pad  = q.pad + PAD_W'(1);
                if (q.pad == PAD_LAST) begin
                    d.st = ST_CHK;
                end
            end
            ST_CHK: begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
                d.err  = cfg_err_i;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, hidx: '0, remain: '0, pad: '0, we: 1'b0,
                   data: 8'h00, rst_req: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign cfg_rst_req_o = q.rst_req;
    assign cfg_we_o      = q.we;
    assign cfg_data_o    = q.data;
    assign done_o        = q.done;
    assign err_o         = q.err;

    // R2
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst_req_o |=> !cfg_rst_req_o);

    // R6
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PAD) |=> (cfg_we_o && (cfg_data_o == 8'h00) && !in_ready_o));

    // R5
    remain_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PAY) |-> (q.remain != '0));

    // R7
    err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

endmodule

// File: tb/cfg_image_loader_bench.sv
module cfg_image_loader_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;
    localparam int NPAD       = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [7:0]  in_data_i = 8'h00;
    logic        in_last_i = 1'b0;
    logic        in_ready_o;
    logic        cfg_rst_req_o;
    logic        cfg_we_o;
    logic [7:0]  cfg_data_o;
    logic        cfg_err_i = 1'b0;
    logic        done_o;
    logic        err_o;
    logic [31:0] version_o;
    logic [31:0] date_o;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int cyc = 0;
    int rst_cyc = 0;
    bit gap_arm = 1'b0;
    logic [8:0] exp_q [$];
    logic [7:0] img [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_image_loader #(
        .LEN_W         (32),
        .SETTLE_CYCLES (SETTLE),
        .PAD_WRITES    (NPAD)
    ) u_cfg_image_loader (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .in_valid_i    (in_valid_i),
        .in_data_i     (in_data_i),
        .in_last_i     (in_last_i),
        .in_ready_o    (in_ready_o),
        .cfg_rst_req_o (cfg_rst_req_o),
        .cfg_we_o      (cfg_we_o),
        .cfg_data_o    (cfg_data_o),
        .cfg_err_i     (cfg_err_i),
        .done_o        (done_o),
        .err_o         (err_o),
        .version_o     (version_o),
        .date_o        (date_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every write strobe
    always @(negedge clk) begin
        cyc++;
        if (rst_n && cfg_rst_req_o) begin
            rst_cyc = cyc;
            gap_arm = 1'b1;
        end
        if (rst_n && cfg_we_o) begin
            wr_count++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected write", longint'(cfg_data_o), 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk(cfg_data_o == e[7:0], "R5 write data", longint'(cfg_data_o), longint'(e[7:0]));
                if (e[8]) begin
                    chk(in_ready_o == 1'b0, "R6 ready low in filler write", longint'(in_ready_o), 0);
                end
                if (gap_arm) begin
                    chk(cyc - rst_cyc == SETTLE + 2, "R2 settle gap", longint'(cyc - rst_cyc), longint'(SETTLE + 2));
                    gap_arm = 1'b0;
                end
            end
        end
    end

    task automatic build(input int len, input logic [31:0] ver, input logic [31:0] date, input int salt);
        for (int i = 0; i < 4; i++) begin
            img[i]      = 8'(len >> (8 * (3 - i)));
            img[4 + i]  = ver[8*(3-i) +: 8];
            img[8 + i]  = date[8*(3-i) +: 8];
            img[12 + i] = 8'(8'hC3 ^ (salt * 7 + i));
        end
        for (int i = 16; i < 64; i++) begin
            img[i] = 8'(salt * 13 + i * 5 + 1);
        end
    endtask

    // Driver: pushes expectations, starts the load and streams n bytes
    task automatic run_load(input int n, input int len, input bit terr, input string tag);
        int fwd;
        int pad;
        bit exp_err;
        int wr0;
        if (n < 16) begin
            fwd = 0; pad = 0; exp_err = 1'b1;
        end else if (n - 16 < len) begin
            fwd = n - 16; pad = 0; exp_err = 1'b1;
        end else begin
            fwd = len; pad = NPAD; exp_err = terr;
        end
        exp_q.push_back({1'b1, 8'h00});
        for (int i = 0; i < fwd; i++) exp_q.push_back({1'b0, img[16 + i]});
        for (int i = 0; i < pad; i++) exp_q.push_back({1'b1, 8'h00});
        wr0 = wr_count;
        cfg_err_i = terr;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            bit acc;
            if (i % 3 == 2) begin
                in_valid_i = 1'b0;
                @(negedge clk);
            end
            in_valid_i = 1'b1;
            in_data_i  = img[i];
            in_last_i  = (i == n - 1);
            acc = 1'b0;
            while (!acc) begin
                acc = in_ready_o;
                @(negedge clk);
            end
        end
        in_valid_i = 1'b0;
        in_last_i  = 1'b0;
        while (!done_o) @(negedge clk);
        @(negedge clk);
        chk(done_o == 1'b1, {tag, " R7 done"}, longint'(done_o), 1);
        chk(err_o == exp_err, {tag, (exp_err && n < 16) ? " R8 err" : " R9 R7 err"},
            longint'(err_o), longint'(exp_err));
        chk(exp_q.size() == 0, {tag, " R5 pending writes"}, longint'(exp_q.size()), 0);
        chk(wr_count - wr0 == 1 + fwd + pad, {tag, " R3 R6 write count"},
            longint'(wr_count - wr0), longint'(1 + fwd + pad));
        chk(in_ready_o == 1'b0, {tag, " R6 ready after end"}, longint'(in_ready_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready_o == 0 && cfg_we_o == 0 && cfg_rst_req_o == 0, "R1 in reset",
            longint'({in_ready_o, cfg_we_o, cfg_rst_req_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o == 0 && err_o == 0, "R1 flags after reset", longint'({done_o, err_o}), 0);

        // R11: offered bytes while idle are ignored
        for (int i = 0; i < 5; i++) begin
            in_valid_i = 1'b1;
            in_data_i  = 8'h5A;
            in_last_i  = 1'b1;
            @(negedge clk);
            chk(in_ready_o == 1'b0, "R11 idle ready", longint'(in_ready_o), 0);
        end
        in_valid_i = 1'b0;
        in_last_i  = 1'b0;
        chk(wr_count == 0, "R11 no idle write", longint'(wr_count), 0);

        // Normal load
        build(6, 32'h1122_3344, 32'h2024_0517, 1);
        run_load(22, 6, 1'b0, "normal");
        chk(version_o == 32'h1122_3344, "R4 version", longint'(version_o), 32'h1122_3344);
        chk(date_o == 32'h2024_0517, "R4 date", longint'(date_o), 32'h2024_0517);

        // Target reports error after padding
        build(3, 32'hA5A5_0001, 32'h0BAD_F00D, 2);
        run_load(19, 3, 1'b1, "target-err");
        chk(version_o == 32'hA5A5_0001, "R4 version second", longint'(version_o), 32'hA5A5_0001);

        // Zero length straight to padding
        build(0, 32'h0000_00FF, 32'h1234_5678, 3);
        run_load(16, 0, 1'b0, "zero-len R10");
        chk(date_o == 32'h1234_5678, "R4 date zero-len", longint'(date_o), 32'h1234_5678);

        // Short header
        build(8, 32'h1, 32'h2, 4);
        run_load(10, 8, 1'b0, "short-hdr R8");

        // Header complete but no payload
        build(4, 32'h3, 32'h4, 5);
        run_load(16, 4, 1'b0, "hdr-only R8");

        // Truncated payload
        build(5, 32'h5, 32'h6, 6);
        run_load(18, 5, 1'b0, "truncated R9");

        // Longer payload, varied reserved bytes
        build(40, 32'hDEAD_BEEF, 32'hCAFE_0042, 9);
        run_load(56, 40, 1'b0, "long R3");
        chk(version_o == 32'hDEAD_BEEF, "R4 version long", longint'(version_o), 32'hDEAD_BEEF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule